// File: doc/BRIEF.md
# Bidirectional Compare-Clear Position Counter

This block keeps a position count that moves one step up or down on each cycle where the count-enable input is high. The direction input selects the step: low counts up, high counts down. Two limit registers clear the count, each for one direction only. When the count already equals limit register A and an up step arrives, the count returns to zero instead of incrementing. When it equals limit register B and a down step arrives, the same happens. A step in the opposite direction passes such a limit normally, with no clear and no interrupt.

Two general channels sit next to the counter. Each channel either compares its stored value against the count and pulses an interrupt on a hit, or captures the count when a selected edge appears on its trigger input. The trigger inputs are asynchronous and pass through a synchronizer before edge detection. All registers are written through a simple address/data write port. The channel values are visible on output ports, so a captured position can be read there.

Top module: `bidir_clear_counter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the count, both limit registers, both channel values and the configuration to zero, and all four interrupt outputs read low in the following cycle.
- R2: When cnt_en is high and no clear applies, a clock edge adds one to the count if cnt_dn is 0 and subtracts one if cnt_dn is 1. When cnt_en is low the count holds.
- R3: Outside a clear, the count wraps from FFFFh to 0000h on an up step and from 0000h to FFFFh on a down step.
- R4: If the count equals limit A (address 0) at an edge with an up step, the count becomes 0000h and irq_lim_a is high for the following cycle.
- R5: If the count equals limit A at an edge with a down step, the count decrements and irq_lim_a stays low.
- R6: If the count equals limit B (address 1) at an edge with a down step, the count becomes 0000h and irq_lim_b is high for the following cycle.
- R7: If the count equals limit B at an edge with an up step, the count increments and irq_lim_b stays low.
- R8: A channel whose mode bit is 0 (compare) raises its irq_ch bit for one cycle after a step edge whose resulting count, including a clear to zero, equals the channel value.
- R9: A channel whose mode bit is 1 (capture) latches the count and raises its irq_ch bit for one cycle when a selected edge reaches it. A trigger change is seen two edges later and acts at the third edge, where the count from before that edge is stored.
- R10: Configuration register (address 4) layout: bit 0 mode of channel 0, bit 1 mode of channel 1, bits 3:2 edge select of channel 0, bits 5:4 edge select of channel 1. Edge select 01 means rising, 10 falling, 11 both, and 00 disables capture, so trigger changes have no effect.
- R11: A write to address 2 or 3 loads channel 0 or 1. If a capture happens in the same cycle, the capture wins and the write is dropped.
- R12: A write to address 0 or 1 loads the limit register. Limit values seen at an edge are those from before any write at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count step enable |
| cnt_dn | input | 1 | Step direction, 1 = down |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 limit A, 1 limit B, 2 channel 0, 3 channel 1, 4 configuration) |
| wr_data | input | 16 | Register write data |
| trig | input | 2 | Asynchronous capture triggers, bit i for channel i |
| count | output | 16 | Current count |
| ch_val0 | output | 16 | Channel 0 stored value |
| ch_val1 | output | 16 | Channel 1 stored value |
| irq_lim_a | output | 1 | Pulse after a clear by limit A |
| irq_lim_b | output | 1 | Pulse after a clear by limit B |
| irq_ch | output | 2 | Per-channel compare-hit or capture pulse |

## Verification
Three things can fall on the same edge. A limit clear can coincide with a compare hit on a channel whose value is zero. A capture can meet a limit clear, and it must store the count from before the clear. A capture can also collide with a software write to the same channel register. The bench sets channel 1 to zero so that every clear also hits it, and it fires triggers while the counter steps through clears. It also sweeps write timing across the capture edge. A behavioural reference model, updated at every edge, judges each outcome on every cycle.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam int ADDR_W     = 3;
   localparam int N_CH       = 2;
   localparam logic [2:0] ADR_LIM_A = 3'd0;
   localparam logic [2:0] ADR_LIM_B = 3'd1;
   localparam logic [2:0] ADR_CH0   = 3'd2;
   localparam logic [2:0] ADR_CH1   = 3'd3;
   localparam logic [2:0] ADR_CFG   = 3'd4;
   localparam int CFG_W      = 6;
endpackage

// File: rtl/bcc_trig_sync.sv
module bcc_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_in,
   output logic rise,
   output logic fall
);
   localparam int TOT = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad
         $error("bcc_trig_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [TOT-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[TOT-2:0], trig_in};
   end

   // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its prior value
   assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/bcc_counter.sv
module bcc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cnt_en,
   input  logic             cnt_dn,
   input  logic [CNT_W-1:0] lim_a,
   input  logic [CNT_W-1:0] lim_b,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             irq_a,
   output logic             irq_b
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic             clr_a, clr_b;

   assign clr_a = cnt_en & ~cnt_dn & (cnt_q == lim_a);
   assign clr_b = cnt_en &  cnt_dn & (cnt_q == lim_b);

   always_comb begin
      if (!cnt_en)            cnt_nxt = cnt_q;
      else if (clr_a | clr_b) cnt_nxt = '0;
      else if (cnt_dn)        cnt_nxt = cnt_q - ONE;
      else                    cnt_nxt = cnt_q + ONE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         irq_a <= 1'b0;
         irq_b <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         irq_a <= clr_a;
         irq_b <= clr_b;
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/bcc_channel.sv
module bcc_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_mode,
   input  logic [1:0]       edge_sel,
   input  logic             t_rise,
   input  logic             t_fall,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_cur,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             wr_hit,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] val,
   output logic             irq
);
   logic             cap;
   logic             hit;
   logic [CNT_W-1:0] val_q;

   assign cap = cap_mode & ((t_rise & edge_sel[0]) | (t_fall & edge_sel[1]));
   assign hit = ~cap_mode & step & (cnt_nxt == val_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         val_q <= '0;
         irq   <= 1'b0;
      end else begin
         irq <= cap | hit;
         if (cap)         val_q <= cnt_cur;
         else if (wr_hit) val_q <= wr_data;
      end
   end

   assign val = val_q;
endmodule

// File: rtl/bidir_clear_counter.sv
module bidir_clear_counter
   import bcc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cnt_en,
   input  logic             cnt_dn,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       trig,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] ch_val0,
   output logic [CNT_W-1:0] ch_val1,
   output logic             irq_lim_a,
   output logic             irq_lim_b,
   output logic [1:0]       irq_ch
);
   generate
      if (CNT_W < CFG_W) begin : g_bad_w
         $error("bidir_clear_counter: CNT_W must hold the configuration field");
      end
   endgenerate

   logic [CNT_W-1:0] lim_a_q, lim_b_q, cnt_nxt;
   logic [CFG_W-1:0] cfg_q;
   logic [CNT_W-1:0] ch_val [N_CH];
   logic [N_CH-1:0]  t_rise, t_fall, wr_ch;

   always_ff @(posedge clk) begin
      if (rst) begin
         lim_a_q <= '0;
         lim_b_q <= '0;
         cfg_q   <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADR_LIM_A) lim_a_q <= wr_data;
         if (wr_addr == ADR_LIM_B) lim_b_q <= wr_data;
         if (wr_addr == ADR_CFG)   cfg_q   <= wr_data[CFG_W-1:0];
      end
   end

   assign wr_ch[0] = wr_en & (wr_addr == ADR_CH0);
   assign wr_ch[1] = wr_en & (wr_addr == ADR_CH1);

   bcc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_dn(cnt_dn),
      .lim_a(lim_a_q), .lim_b(lim_b_q), .count(count), .cnt_nxt(cnt_nxt),
      .irq_a(irq_lim_a), .irq_b(irq_lim_b)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      bcc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst(rst), .trig_in(trig[i]),
         .rise(t_rise[i]), .fall(t_fall[i])
      );
      bcc_channel #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst(rst),
         .cap_mode(cfg_q[i]), .edge_sel(cfg_q[2+2*i +: 2]),
         .t_rise(t_rise[i]), .t_fall(t_fall[i]),
         .step(cnt_en), .cnt_cur(count), .cnt_nxt(cnt_nxt),
         .wr_hit(wr_ch[i]), .wr_data(wr_data),
         .val(ch_val[i]), .irq(irq_ch[i])
      );
   end

   assign ch_val0 = ch_val[0];
   assign ch_val1 = ch_val[1];
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             cnt_en,
   input logic             cnt_dn,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] lim_a,
   input logic [CNT_W-1:0] lim_b,
   input logic             irq_lim_a,
   input logic             irq_lim_b,
   input logic [1:0]       irq_ch,
   input logic [5:0]       cfg,
   input logic [CNT_W-1:0] ch_val0
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |=> $stable(count)); // R2
   AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && !cnt_dn && count == '1 && lim_a != '1) |=> count == '0); // R3
   AST_LIM_A_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && !cnt_dn && count == lim_a) |=> (count == '0 && irq_lim_a)); // R4
   AST_LIM_A_PASS: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && cnt_dn && count == lim_a && count != lim_b)
      |=> (count == $past(count) - ONE && !irq_lim_a)); // R5
   AST_LIM_B_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && cnt_dn && count == lim_b) |=> (count == '0 && irq_lim_b)); // R6
   AST_LIM_B_PASS: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && !cnt_dn && count == lim_b && count != lim_a)
      |=> (count == $past(count) + ONE && !irq_lim_b)); // R7
   AST_CH0_HIT: assert property (@(posedge clk) disable iff (rst)
      (irq_ch[0] && !$past(cfg[0])) |-> count == $past(ch_val0)); // R8
   AST_CH0_OFF: assert property (@(posedge clk) disable iff (rst)
      ($past(cfg[0]) && $past(cfg[3:2]) == 2'b00) |-> !irq_ch[0]); // R10
endmodule

bind bidir_clear_counter bcc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_dn(cnt_dn), .count(count),
   .lim_a(lim_a_q), .lim_b(lim_b_q), .irq_lim_a(irq_lim_a),
   .irq_lim_b(irq_lim_b), .irq_ch(irq_ch), .cfg(cfg_q), .ch_val0(ch_val0)
);

// File: tb/bidir_clear_counter_test.sv
module bidir_clear_counter_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0, rst = 1, cnt_en = 0, cnt_dn = 0, wr_en = 0;
   logic [2:0]  wr_addr = 0;
   logic [15:0] wr_data = 0;
   logic [1:0]  trig = 0;
   logic [15:0] count, ch_val0, ch_val1;
   logic        irq_lim_a, irq_lim_b;
   logic [1:0]  irq_ch;

   int errors = 0, checks = 0, cyc = 0;
   bit done = 0;

   bidir_clear_counter uut (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_dn(cnt_dn), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .trig(trig), .count(count),
      .ch_val0(ch_val0), .ch_val1(ch_val1), .irq_lim_a(irq_lim_a),
      .irq_lim_b(irq_lim_b), .irq_ch(irq_ch)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model state
   logic [15:0] m_cnt, m_la, m_lb, m_val[2];
   logic [5:0]  m_cfg;
   logic [2:0]  m_sh[2];   // [0] first flop, [1] synced, [2] prior
   logic        m_ia, m_ib;
   logic [1:0]  m_ich;

   always @(posedge clk) begin
      logic [15:0] nc;
      logic        cap;
      if (rst) begin
         m_cnt = 0; m_la = 0; m_lb = 0; m_cfg = 0;
         m_val[0] = 0; m_val[1] = 0; m_sh[0] = 0; m_sh[1] = 0;
         m_ia = 0; m_ib = 0; m_ich = 0;
      end else begin
         m_ia = 0; m_ib = 0;
         nc = m_cnt;
         if (cnt_en) begin
            if (!cnt_dn && m_cnt == m_la)     begin nc = 0; m_ia = 1; end
            else if (cnt_dn && m_cnt == m_lb) begin nc = 0; m_ib = 1; end
            else if (cnt_dn)                  nc = m_cnt - 16'd1;
            else                              nc = m_cnt + 16'd1;
         end
         for (int i = 0; i < 2; i++) begin
            bit r, f;
            r = m_sh[i][1] && !m_sh[i][2];
            f = !m_sh[i][1] && m_sh[i][2];
            cap = m_cfg[i] && ((r && m_cfg[2+2*i]) || (f && m_cfg[3+2*i]));
            m_ich[i] = cap || (!m_cfg[i] && cnt_en && nc == m_val[i]);
            if (cap) m_val[i] = m_cnt;
            else if (wr_en && wr_addr == 3'(2+i)) m_val[i] = wr_data;
            m_sh[i] = {m_sh[i][1:0], trig[i]};
         end
         if (wr_en && wr_addr == 0) m_la = wr_data;
         if (wr_en && wr_addr == 1) m_lb = wr_data;
         if (wr_en && wr_addr == 4) m_cfg = wr_data[5:0];
         m_cnt = nc;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst && !done) begin
         chk("R2 R3 R4 R5 R6 R7 count", count, m_cnt);
         chk("R4 R5 irq_lim_a", irq_lim_a, m_ia);
         chk("R6 R7 irq_lim_b", irq_lim_b, m_ib);
         chk("R8 R9 R10 irq_ch", irq_ch, m_ich);
         chk("R9 R11 ch_val0", ch_val0, m_val[0]);
         chk("R9 R11 ch_val1", ch_val1, m_val[1]);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic tick(bit en, bit dn);
      cnt_en = en; cnt_dn = dn;
      @(negedge clk);
      cnt_en = 0;
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", count, 0);
      chk("R1 irqs", {irq_lim_a, irq_lim_b, irq_ch}, 0);
      chk("R1 ch_val0", ch_val0, 0);

      // R12 / R4 / R7: limit A = 5, limit B = 3, count up through B to A
      wr(0, 16'd5); wr(1, 16'd3);
      wr(2, 16'd2); wr(3, 16'd0);  // compare channels: 2 and 0
      chk("R11 ch_val0 write", ch_val0, 2);
      tick(1, 0); tick(1, 0);
      chk("R8 irq_ch0 on hit", irq_ch[0], 1);
      tick(1, 0);
      chk("R2 count up", count, 3);
      tick(1, 0);
      chk("R7 pass limit B upward", count, 4);
      chk("R7 no irq_lim_b", irq_lim_b, 0);
      tick(1, 0); tick(1, 0);
      chk("R4 clear at limit A", count, 0);
      chk("R4 irq_lim_a", irq_lim_a, 1);
      chk("R8 irq_ch1 on clear to zero", irq_ch[1], 1);
      tick(0, 0);
      chk("R2 hold", count, 0);
      chk("R4 pulse one cycle", irq_lim_a, 0);

      // R3 / R5 / R6: down path
      wr(0, 16'hFFFE); wr(1, 16'hFFFD);
      tick(1, 1);
      chk("R3 wrap down", count, 16'hFFFF);
      tick(1, 1); tick(1, 1);
      chk("R5 pass limit A downward", count, 16'hFFFD);
      chk("R5 no irq_lim_a", irq_lim_a, 0);
      tick(1, 1);
      chk("R6 clear at limit B", count, 0);
      chk("R6 irq_lim_b", irq_lim_b, 1);
      tick(1, 1);
      tick(1, 0);
      chk("R3 wrap up", count, 0);

      // R9 capture, channel 0 rising, channel 1 both edges
      wr(4, 16'b11_01_11);
      tick(1, 0); tick(1, 0); tick(1, 0);
      trig = 2'b11;
      repeat (4) @(negedge clk);
      chk("R9 capture rising ch0", ch_val0, 3);
      chk("R9 capture ch1", ch_val1, 3);
      trig = 2'b00;
      repeat (4) @(negedge clk);
      chk("R9 falling ignored by ch0", ch_val0, 3);
      // R10 edge select off
      wr(4, 16'b00_00_01);
      tick(1, 0);
      trig = 2'b01;
      repeat (4) @(negedge clk);
      chk("R10 disabled edge no capture", ch_val0, 3);
      trig = 2'b00;
      repeat (4) @(negedge clk);

      // R11 write vs capture timing sweep while counting through clears
      wr(0, 16'd7); wr(1, 16'hFFF0); wr(3, 16'd0); wr(4, 16'b00_11_01);
      for (int k = 0; k < 6; k++) begin
         trig[0] = ~trig[0];
         repeat (k) tick(1, 0);
         wr(2, 16'h1234 + 16'(k));
         repeat (4) tick(1, 0);
      end

      // mixed random stimulus
      for (int n = 0; n < 3000; n++) begin
         cnt_en = ($urandom % 4) != 0;
         cnt_dn = ($urandom % 3) == 0;
         trig   = 2'($urandom);
         wr_en  = ($urandom % 8) == 0;
         wr_addr = 3'($urandom % 5);
         wr_data = (wr_addr == 4) ? 16'($urandom % 64) : 16'($urandom % 12);
         @(negedge clk);
      end
      wr_en = 0; cnt_en = 0;
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule